// File: doc/BRIEF.md
# Four-Line GPIO Controller Behind a Command Window

This block drives four general-purpose pins whose configuration registers are not mapped directly onto the host bus. The host sees three 32-bit ports. The first is an enable word. The second is a command port: a single word written there names an internal register, carries one byte of data and says whether that byte is to be stored. The third is a read-back port that returns the byte of the most recently named internal register.

Each pin has two 2-bit fields, one in each of two byte-wide internal registers. The control field chooses between driving low, driving high and input. The mode field switches the pin on or off. A pin drives its pad only when it is switched on and its control field asks for a driven level. In every other case the output enable is low and the pin floats. To release a pin, the host clears its mode field and returns its control field to input.

Top module: `gpio4_indirect`

## Requirements
- R1: After reset the enable word reads 0, the control register holds 0xAA (every line code 2), the mode register holds 0x00, and all pad enables and pad outputs are 0.
- R2: The enable word at host offset 0x44 holds all 32 bits written to it and reads them back, so a read-modify-write that sets bit 0 preserves the other bits; bit 0 set grants access to the internal registers.
- R3: While enable bit 0 is clear, command words with bit 24 set change no internal register, and the read-back port at offset 0x6C returns 0.
- R4: A command word written to offset 0x68 with bit 24 set and address field (the word with bits 24:16 cleared) equal to 0x18005020 stores bits 23:16 into the control register.
- R5: A command word with bit 24 clear only selects its register; afterwards offset 0x6C returns that register's byte in bits 7:0 with bits 31:8 zero, and no register changes.
- R6: The same write and select rules apply to the mode register at internal address 0x18005022.
- R7: Line n uses bits [2n+1:2n] of each register. Its pad is driven (enable 1) only when its mode code is 1 and its control code is 0 or 1, and the driven level is 0 for code 0 and 1 for code 1. Control codes 2 and 3 and mode codes 0, 2 and 3 leave the enable at 0 and the output at 0.
- R8: Command words whose address field matches neither internal register change nothing, and a select of such an address makes the read-back port return 0.
- R9: Releasing one line (mode 0, control 2) floats that pad and leaves the other lines' pads unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the addressed port |
| host_addr | input | 8 | Host port offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the port at host_addr (combinational) |
| pad_o | output | 4 | Pad output level per line |
| pad_oe | output | 4 | Pad output enable per line |

## Verification
The bench first issues a store command while access is still locked, then unlocks access and reads the control register back. A design that ignored the lock would return the locked write's byte and not 0xAA. Control code 3 and mode codes 2 and 3 are exercised, because a decoder that tests only one bit of a field would drive pads that must float. A store to an address one step past the mode register has to leave both registers intact, which catches partial address decoding. Releasing one line out of four all-driven lines shows whether field positions are shifted correctly, since a wrong shift would float the wrong pad.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
   localparam int unsigned HOST_W   = 32;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned OFS_W    = 8;
   localparam int unsigned FLAG_BIT = 24;
   localparam int unsigned DATA_LSB = 16;

   localparam logic [OFS_W-1:0]  OFS_ENABLE = 8'h44;
   localparam logic [OFS_W-1:0]  OFS_CMD    = 8'h68;
   localparam logic [OFS_W-1:0]  OFS_RBACK  = 8'h6C;

   localparam logic [HOST_W-1:0] IADDR_CTRL = 32'h1800_5020;
   localparam logic [HOST_W-1:0] IADDR_MODE = 32'h1800_5022;

   typedef enum logic [1:0] {
      CTL_LOW  = 2'd0,
      CTL_HIGH = 2'd1,
      CTL_IN   = 2'd2,
      CTL_RSVD = 2'd3
   } ctl_code_e;

   typedef enum logic [1:0] {
      MD_OFF = 2'd0,
      MD_ON  = 2'd1,
      MD_R2  = 2'd2,
      MD_R3  = 2'd3
   } mode_code_e;

   typedef struct packed {
      logic              hit_ctrl;
      logic              hit_mode;
      logic              store;
      logic [BYTE_W-1:0] data;
   } cmd_t;
endpackage

// File: rtl/gpio4_cmd_decode.sv
module gpio4_cmd_decode
   import gpio4_pkg::*;
#(
   parameter int unsigned WORD_W  = HOST_W,
   parameter int unsigned DATA_W  = BYTE_W,
   parameter int unsigned DLSB    = DATA_LSB,
   parameter int unsigned WR_BIT  = FLAG_BIT
) (
   input  logic [WORD_W-1:0] cmd_word,
   output cmd_t              cmd
);
   localparam int unsigned DMSB = DLSB + DATA_W - 1;

   initial begin
      assert (WR_BIT > DMSB && WR_BIT < WORD_W)
         else $fatal(1, "write flag must sit above the data field");
   end

   logic [WORD_W-1:0] field_mask;
   logic [WORD_W-1:0] iaddr;

   always_comb begin
      field_mask = '0;
      for (int b = DLSB; b <= int'(WR_BIT); b++) field_mask[b] = 1'b1;
      iaddr        = cmd_word & ~field_mask;
      cmd.hit_ctrl = (iaddr == IADDR_CTRL);
      cmd.hit_mode = (iaddr == IADDR_MODE);
      cmd.store    = cmd_word[WR_BIT];
      cmd.data     = cmd_word[DMSB:DLSB];
   end
endmodule

// File: rtl/gpio4_line_drv.sv
module gpio4_line_drv
   import gpio4_pkg::*;
#(
   parameter int unsigned FLD_W = 2
) (
   input  logic [FLD_W-1:0] ctl_fld,
   input  logic [FLD_W-1:0] mode_fld,
   output logic             drv_o,
   output logic             drv_oe
);
   initial begin
      assert (FLD_W == 2) else $fatal(1, "line fields are two bits");
   end

   ctl_code_e  ctl;
   mode_code_e md;
   logic       drive;

   always_comb begin
      ctl    = ctl_code_e'(ctl_fld);
      md     = mode_code_e'(mode_fld);
      drive  = (md == MD_ON) && (ctl == CTL_LOW || ctl == CTL_HIGH);
      drv_oe = drive;
      drv_o  = drive && (ctl == CTL_HIGH);
   end
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
   import gpio4_pkg::*;
#(
   parameter int unsigned LINES = 4,
   parameter int unsigned FLD_W = 2,
   parameter int unsigned REG_W = LINES * FLD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic [HOST_W-1:0] en_wdata,
   input  logic              cmd_wr,
   input  cmd_t              cmd,
   output logic [HOST_W-1:0] en_q,
   output logic [REG_W-1:0]  ctrl_q,
   output logic [REG_W-1:0]  mode_q,
   output logic [REG_W-1:0]  rback
);
   localparam logic [REG_W-1:0] CTRL_RST = {LINES{CTL_IN}};
   localparam logic [REG_W-1:0] MODE_RST = {LINES{MD_OFF}};

   initial begin
      assert (REG_W == BYTE_W) else $fatal(1, "register width must match data byte");
   end

   logic sel_ctrl, sel_mode;
   logic unlocked;

   assign unlocked = en_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         ctrl_q   <= CTRL_RST;
         mode_q   <= MODE_RST;
         sel_ctrl <= 1'b0;
         sel_mode <= 1'b0;
      end else begin
         if (en_wr) en_q <= en_wdata;
         if (cmd_wr) begin
            sel_ctrl <= cmd.hit_ctrl;
            sel_mode <= cmd.hit_mode;
            if (unlocked && cmd.store) begin
               if (cmd.hit_ctrl) ctrl_q <= cmd.data;
               if (cmd.hit_mode) mode_q <= cmd.data;
            end
         end
      end
   end

   always_comb begin
      rback = '0;
      if (unlocked) begin
         if (sel_ctrl)      rback = ctrl_q;
         else if (sel_mode) rback = mode_q;
      end
   end
endmodule

// File: rtl/gpio4_indirect.sv
module gpio4_indirect
   import gpio4_pkg::*;
#(
   parameter int unsigned LINES = 4,
   parameter int unsigned FLD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [7:0]        host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic [LINES-1:0]  pad_o,
   output logic [LINES-1:0]  pad_oe
);
   localparam int unsigned REG_W = LINES * FLD_W;

   initial begin
      assert (REG_W == BYTE_W) else $fatal(1, "LINES*FLD_W must equal eight");
   end

   cmd_t              cmd;
   logic [HOST_W-1:0] en_q;
   logic [REG_W-1:0]  ctrl_q, mode_q, rback;
   logic              en_wr, cmd_wr;

   assign en_wr  = host_wr && (host_addr == OFS_ENABLE);
   assign cmd_wr = host_wr && (host_addr == OFS_CMD);

   gpio4_cmd_decode u_dec (
      .cmd_word (host_wdata),
      .cmd      (cmd)
   );

   gpio4_regs #(.LINES(LINES), .FLD_W(FLD_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (en_wr),
      .en_wdata (host_wdata),
      .cmd_wr   (cmd_wr),
      .cmd      (cmd),
      .en_q     (en_q),
      .ctrl_q   (ctrl_q),
      .mode_q   (mode_q),
      .rback    (rback)
   );

   for (genvar n = 0; n < LINES; n++) begin : g_line
      gpio4_line_drv #(.FLD_W(FLD_W)) u_drv (
         .ctl_fld  (ctrl_q[n*FLD_W +: FLD_W]),
         .mode_fld (mode_q[n*FLD_W +: FLD_W]),
         .drv_o    (pad_o[n]),
         .drv_oe   (pad_oe[n])
      );
   end

   always_comb begin
      case (host_addr)
         OFS_ENABLE: host_rdata = en_q;
         OFS_RBACK:  host_rdata = {{(HOST_W-REG_W){1'b0}}, rback};
         default:    host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio4_indirect_chk.sv
module gpio4_indirect_chk #(
   parameter int unsigned LINES = 4,
   parameter int unsigned FLD_W = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     host_wr,
   input logic [7:0]               host_addr,
   input logic [31:0]              host_wdata,
   input logic                     unlocked,
   input logic [LINES*FLD_W-1:0]   ctrl_q,
   input logic [LINES*FLD_W-1:0]   mode_q,
   input logic [LINES-1:0]         pad_o,
   input logic [LINES-1:0]         pad_oe
);
   logic cmd_w, addr_ctrl, addr_mode;
   assign cmd_w     = host_wr && host_addr == 8'h68;
   assign addr_ctrl = (host_wdata & ~32'h01FF_0000) == 32'h1800_5020;
   assign addr_mode = (host_wdata & ~32'h01FF_0000) == 32'h1800_5022;

   // R3
   locked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !unlocked) |=> ($stable(ctrl_q) && $stable(mode_q)));

   // R4
   ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && unlocked && host_wdata[24] && addr_ctrl) |=> (ctrl_q == $past(host_wdata[23:16])));

   // R5
   select_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !host_wdata[24]) |=> ($stable(ctrl_q) && $stable(mode_q)));

   // R8
   stray_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !addr_ctrl && !addr_mode) |=> ($stable(ctrl_q) && $stable(mode_q)));

   for (genvar n = 0; n < LINES; n++) begin : g_pad
      // R7
      pad_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pad_oe[n] |-> (mode_q[n*FLD_W +: FLD_W] == 2'd1 && !ctrl_q[n*FLD_W+1]));
      // R7
      pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pad_oe[n] |-> !pad_o[n]);
   end
endmodule

bind gpio4_indirect gpio4_indirect_chk #(.LINES(LINES), .FLD_W(FLD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .unlocked   (en_q[0]),
   .ctrl_q     (ctrl_q),
   .mode_q     (mode_q),
   .pad_o      (pad_o),
   .pad_oe     (pad_oe)
);

// File: tb/gpio4_indirect_tb.sv
module gpio4_indirect_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = 8'h00;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [3:0]  pad_o, pad_oe;

   int total = 0;
   int bad = 0;

   localparam logic [31:0] A_CTRL = 32'h1800_5020;
   localparam logic [31:0] A_MODE = 32'h1800_5022;

   always #4 clk = ~clk;

   gpio4_indirect dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .pad_o(pad_o), .pad_oe(pad_oe)
   );

   function automatic logic [31:0] mk_cmd(logic [31:0] a, logic [7:0] d, logic st);
      return a | ({24'h0, d} << 16) | ({31'h0, st} << 24);
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic host_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic sel_read(logic [31:0] a, output logic [31:0] d);
      host_write(8'h68, mk_cmd(a, 8'h00, 1'b0));
      host_read(8'h6C, d);
   endtask

   // expected pads from the per-line rule
   task automatic check_pads(string req, logic [7:0] c, logic [7:0] m);
      logic [3:0] eo, eoe;
      for (int n = 0; n < 4; n++) begin
         eoe[n] = (m[2*n +: 2] == 2'd1) && (c[2*n +: 2] <= 2'd1);
         eo[n]  = eoe[n] && (c[2*n +: 2] == 2'd1);
      end
      @(negedge clk);
      check({req, " oe"}, {28'h0, pad_oe}, {28'h0, eoe});
      check({req, " out"}, {28'h0, pad_o}, {28'h0, eo});
   endtask

   task automatic t_reset;
      logic [31:0] d;
      host_read(8'h44, d);
      check("R1 enable word", d, 32'h0);
      check_pads("R1 pads", 8'hAA, 8'h00);
      check("R1 oe zero", {28'h0, pad_oe}, 32'h0);
   endtask

   task automatic t_locked;
      logic [31:0] d;
      host_write(8'h68, mk_cmd(A_CTRL, 8'h55, 1'b1));
      host_write(8'h68, mk_cmd(A_MODE, 8'h55, 1'b1));
      host_read(8'h6C, d);
      check("R3 readback locked", d, 32'h0);
      check_pads("R3 pads locked", 8'hAA, 8'h00);
   endtask

   task automatic t_unlock;
      logic [31:0] d;
      host_write(8'h44, 32'hC0DE_0000);
      host_read(8'h44, d);
      host_write(8'h44, d | 32'h1);
      host_read(8'h44, d);
      check("R2 rmw enable", d, 32'hC0DE_0001);
      sel_read(A_CTRL, d);
      check("R3 ctrl untouched while locked", d, 32'h0000_00AA);
      sel_read(A_MODE, d);
      check("R3 mode untouched while locked", d, 32'h0);
   endtask

   task automatic t_ctrl_mode;
      logic [31:0] d;
      host_write(8'h68, mk_cmd(A_CTRL, 8'h1B, 1'b1));
      sel_read(A_CTRL, d);
      check("R4 R5 ctrl store", d, 32'h0000_001B);
      host_write(8'h68, mk_cmd(A_MODE, 8'h55, 1'b1));
      sel_read(A_MODE, d);
      check("R6 mode store", d, 32'h0000_0055);
      check_pads("R7 codes 3 2 1 0", 8'h1B, 8'h55);
      host_write(8'h68, mk_cmd(A_CTRL, 8'h00, 1'b1));
      host_write(8'h68, mk_cmd(A_MODE, 8'hE4, 1'b1));
      check_pads("R7 mode codes", 8'h00, 8'hE4);
      host_write(8'h68, mk_cmd(A_CTRL, 8'h00, 1'b0));
      host_read(8'h6C, d);
      check("R5 select keeps ctrl", d, 32'h0);
   endtask

   task automatic t_stray;
      logic [31:0] d;
      host_write(8'h68, mk_cmd(A_MODE + 32'h2, 8'hFF, 1'b1));
      sel_read(A_CTRL, d);
      check("R8 ctrl kept", d, 32'h0);
      sel_read(A_MODE, d);
      check("R8 mode kept", d, 32'h0000_00E4);
      sel_read(A_MODE + 32'h2, d);
      check("R8 stray readback", d, 32'h0);
   endtask

   task automatic t_release;
      logic [31:0] c, m;
      host_write(8'h68, mk_cmd(A_CTRL, 8'h55, 1'b1));
      host_write(8'h68, mk_cmd(A_MODE, 8'h55, 1'b1));
      check_pads("R9 all high", 8'h55, 8'h55);
      sel_read(A_CTRL, c);
      sel_read(A_MODE, m);
      c = (c & ~32'h30) | 32'h20;
      m = m & ~32'h30;
      host_write(8'h68, mk_cmd(A_CTRL, c[7:0], 1'b1));
      host_write(8'h68, mk_cmd(A_MODE, m[7:0], 1'b1));
      check("R9 line2 floats", {28'h0, pad_oe}, 32'h0000_000B);
      check_pads("R9 released", 8'h65, 8'h45);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset;
            t_locked;
            t_unlock;
            t_ctrl_mode;
            t_stray;
            t_release;
         end
         begin
            repeat (200000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog got=hang exp=done");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule